// File: doc/BRIEF.md
# Decoder Register Access Master

This block is the control-port master for an external audio decoder. A requester presents one register operation at a time: a direction flag, an 8-bit register address and, for writes, a 16-bit value. The block turns that request into a serial command on a chip-select / clock / data-out / data-in link. For a read, it returns the 16-bit result together with a one-cycle completion pulse.

The serial clock and data-out wires are shared with a separate streaming shifter that carries the decoder's audio data. For the whole of each register transaction the block withdraws that shifter's enable. When the transaction ends, it hands the lines back and clears the shifter's completion flag.

Each serial bit has two phases. In the low phase the clock stays low for `LO_CYC` system cycles while the data-out line settles. In the high phase the clock stays high for `HI_CYC` cycles. Every command is 32 bits long.

Top module: `dcm_reg_master`

## Requirements
- R1: While reset is held, chip select is high, the serial clock and data-out are low, busy/done/flag-clear are low, the stream enable is high and read data is zero.
- R2: A write request (req_write=1) sends, MSB first, the opcode 0x02, then the address byte, then write data bits 15..8, then bits 7..0, with chip select low for all 32 bits.
- R3: A read request (req_write=0) sends, MSB first, the opcode 0x03 and then the address byte. It then shifts in 16 bits from the data-in line, first bit into bit 15, and presents them on rdata in the done cycle.
- R4: Each bit holds the clock low for LO_CYC cycles and then high for HI_CYC cycles. Data-out takes its value during the low phase and does not change while the clock is high.
- R5: Each input bit is the data-in value in the last system cycle of that bit's high phase. Values in earlier cycles of the bit have no effect.
- R6: done is high for exactly one cycle, in the cycle after the 32*(LO_CYC+HI_CYC)-th rising edge following the accepting edge. Busy is high from acceptance through the done cycle.
- R7: A request is accepted only when busy is low. A request held or changed while busy alters neither the bits sent nor the number of transactions.
- R8: The stream enable is low from acceptance through the done cycle. The stream flag-clear pulses together with done, and the enable is high again in the following cycle.
- R9: rdata changes only at the completion of a read. Writes and idle cycles leave it unchanged.
- R10: Outside a transaction, and in the done cycle, chip select is high and the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| ctl_csn | output | 1 | Active-low chip select |
| ctl_sclk | output | 1 | Serial clock, idles low |
| ctl_mosi | output | 1 | Serial data to decoder |
| ctl_miso | input | 1 | Serial data from decoder |
| strm_enable | output | 1 | Enable for the shared streaming shifter |
| strm_flag_clr | output | 1 | Clears the streaming shifter's completion flag |

## Verification
The block registers the request on the accepting edge, so the first low-phase cycle is visible at the next falling edge. Each bit then spans exactly LO_CYC falling edges with the clock low, followed by HI_CYC falling edges with the clock high. Done, flag-clear and the read result are due at falling edge 32*(LO_CYC+HI_CYC)+1 after acceptance, and idle plus the restored stream enable one edge later. The bench walks those exact edge counts for every transaction and samples every output at each falling edge. It changes the data-in line only in the final high cycle of a bit, driving the complement everywhere else, so that a sample taken early or late is detected. It sweeps all addresses with writes and every second address with reads, holding or altering the request mid-transaction on some of them.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int OP_W    = 8;
    localparam int ADR_W   = 8;
    localparam int DAT_W   = 16;
    localparam int FRAME_W = OP_W + ADR_W + DAT_W;

    localparam logic [OP_W-1:0] OP_WRITE = 8'h02;
    localparam logic [OP_W-1:0] OP_READ  = 8'h03;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOW,
        SEQ_HIGH,
        SEQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic             wr;
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] wdata;
    } reg_req_t;

    // Outgoing 32-bit command; the read tail is zero filler while data comes in.
    function automatic logic [FRAME_W-1:0] pack_frame(reg_req_t r);
        return {(r.wr ? OP_WRITE : OP_READ), r.addr,
                (r.wr ? r.wdata : {DAT_W{1'b0}})};
    endfunction
endpackage

// File: rtl/dcm_phase_timer.sv
module dcm_phase_timer #(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic in_high,
    output logic phase_last
);
    localparam int MAX_C = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign phase_last = run && (cnt_q == (in_high ? HI_LAST : LO_LAST));

    always_ff @(posedge clk) begin
        if (rst || !run || phase_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= (in_high ? HI_LAST : LO_LAST)));
endmodule

// File: rtl/dcm_sequencer.sv
module dcm_sequencer
    import dcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       phase_last,
    output seq_state_t state,
    output logic       accept,
    output logic       bit_step,
    output logic       last_step
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    seq_state_t       st_q, st_d;
    logic [BIT_W-1:0] bit_q;

    assign state     = st_q;
    assign accept    = (st_q == SEQ_IDLE) && req_valid;
    assign bit_step  = (st_q == SEQ_HIGH) && phase_last;
    assign last_step = bit_step && (bit_q == LAST_BIT);

    always_comb begin
        st_d = st_q;
        case (st_q)
            SEQ_IDLE: if (req_valid)  st_d = SEQ_LOW;
            SEQ_LOW:  if (phase_last) st_d = SEQ_HIGH;
            SEQ_HIGH: if (phase_last) st_d = (bit_q == LAST_BIT) ? SEQ_DONE : SEQ_LOW;
            SEQ_DONE: st_d = SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            bit_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                bit_q <= '0;
            end else if (bit_step) begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    // R6
    done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_DONE) |=> (st_q == SEQ_IDLE));

    // R7
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SEQ_DONE) && req_valid |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/dcm_shift_path.sv
module dcm_shift_path
    import dcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  reg_req_t         req,
    input  logic             step,
    input  logic             last_step,
    input  logic             miso,
    output logic             mosi,
    output logic [DAT_W-1:0] rdata
);
    logic [FRAME_W-1:0] frame_q;
    logic               rd_q;
    logic [DAT_W-2:0]   cap_q;
    logic [DAT_W-1:0]   rdata_q;

    assign mosi  = frame_q[FRAME_W-1];
    assign rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (load) begin
                frame_q <= pack_frame(req);
                rd_q    <= !req.wr;
            end else if (step) begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
            end
            if (step) begin
                cap_q <= {cap_q[DAT_W-3:0], miso};
            end
            if (last_step && rd_q) begin
                rdata_q <= {cap_q, miso};
            end
        end
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last_step |=> $stable(rdata_q));
endmodule

// File: rtl/dcm_reg_master.sv
module dcm_reg_master
    import dcm_pkg::*;
#(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ADR_W-1:0] req_addr,
    input  logic [DAT_W-1:0] req_wdata,
    output logic             busy,
    output logic             done,
    output logic [DAT_W-1:0] rdata,
    output logic             ctl_csn,
    output logic             ctl_sclk,
    output logic             ctl_mosi,
    input  logic             ctl_miso,
    output logic             strm_enable,
    output logic             strm_flag_clr
);
    seq_state_t state;
    logic       accept, bit_step, last_step, phase_last;
    reg_req_t   req_s;

    assign req_s = {req_write, req_addr, req_wdata};

    dcm_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .phase_last (phase_last),
        .state      (state),
        .accept     (accept),
        .bit_step   (bit_step),
        .last_step  (last_step)
    );

    dcm_phase_timer #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        ((state == SEQ_LOW) || (state == SEQ_HIGH)),
        .in_high    (state == SEQ_HIGH),
        .phase_last (phase_last)
    );

    dcm_shift_path u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .req       (req_s),
        .step      (bit_step),
        .last_step (last_step),
        .miso      (ctl_miso),
        .mosi      (ctl_mosi),
        .rdata     (rdata)
    );

    assign busy          = (state != SEQ_IDLE);
    assign done          = (state == SEQ_DONE);
    assign ctl_csn       = !((state == SEQ_LOW) || (state == SEQ_HIGH));
    assign ctl_sclk      = (state == SEQ_HIGH);
    assign strm_enable   = (state == SEQ_IDLE);
    assign strm_flag_clr = (state == SEQ_DONE);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_sclk && $past(ctl_sclk) |-> $stable(ctl_mosi));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    strm_off_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !strm_enable);

    // R8
    strm_back_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> strm_enable && !strm_flag_clr);

    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy || done) |-> ctl_csn && !ctl_sclk);
endmodule

// File: tb/dcm_reg_master_tb_top.sv
module dcm_reg_master_tb_top;
    localparam int LO = 2;
    localparam int HI = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid, req_write, ctl_miso;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata;
    logic        busy, done, ctl_csn, ctl_sclk, ctl_mosi, strm_enable, strm_flag_clr;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    dcm_reg_master #(.LO_CYC(LO), .HI_CYC(HI)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ctl_csn(ctl_csn), .ctl_sclk(ctl_sclk), .ctl_mosi(ctl_mosi),
        .ctl_miso(ctl_miso), .strm_enable(strm_enable), .strm_flag_clr(strm_flag_clr)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] wpat(input int a);
        return 16'(a * 257) ^ 16'h3C96;
    endfunction

    function automatic logic [15:0] rpat(input int a);
        return ~(16'(a * 4099) ^ 16'h5A21);
    endfunction

    // Starts at a falling edge with the block idle; ends at the falling edge of the idle cycle after done.
    task automatic run_txn(input bit wr, input logic [7:0] a, input logic [15:0] wd,
                           input logic [15:0] rp, input bit hold);
        logic [31:0] ef;
        logic [15:0] exp_rd;
        logic        mb;
        ef     = wr ? {8'h02, a, wd} : {8'h03, a, 16'h0000};
        exp_rd = wr ? rdata : rp;
        mb     = 1'b0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        for (int b = 0; b < 32; b++) begin
            for (int c = 0; c < LO; c++) begin
                @(negedge clk);
                if (b == 0 && c == 0) begin
                    if (hold) begin
                        req_write = ~wr; req_addr = ~a; req_wdata = ~wd;
                    end else begin
                        req_valid = 1'b0;
                    end
                end
                ctl_miso = (b >= 16) ? ~rp[31-b] : 1'b1;
                // R4 low phase, R8 stream held off, R6 no early done
                chk(!ctl_sclk && !ctl_csn, "R4", {ctl_sclk, ctl_csn}, 2'b00);
                chk(busy && !strm_enable && !done && !strm_flag_clr, "R8",
                    {busy, strm_enable, done, strm_flag_clr}, 4'b1000);
                if (c == 0) mb = ctl_mosi;
                else chk(ctl_mosi == mb, "R4", ctl_mosi, mb);
            end
            if (wr || b < 16) chk(mb == ef[31-b], wr ? "R2" : "R3", mb, ef[31-b]);
            for (int c = 0; c < HI; c++) begin
                @(negedge clk);
                // R5: only the final high cycle carries the true bit
                ctl_miso = (b >= 16) ? ((c == HI - 1) ? rp[31-b] : ~rp[31-b]) : 1'b0;
                chk(ctl_sclk && !ctl_csn && !done, "R4", {ctl_sclk, ctl_csn, done}, 3'b100);
                chk(ctl_mosi == mb, "R4", ctl_mosi, mb);
            end
        end
        @(negedge clk);
        chk(done && busy, "R6", {done, busy}, 2'b11);
        chk(ctl_csn && !ctl_sclk, "R10", {ctl_csn, ctl_sclk}, 2'b10);
        chk(strm_flag_clr && !strm_enable, "R8", {strm_flag_clr, strm_enable}, 2'b10);
        chk(rdata == exp_rd, wr ? "R9" : "R5", rdata, exp_rd);
        @(negedge clk);
        chk(!done, "R6", done, 0);
        chk(!busy, hold ? "R7" : "R6", busy, 0);
        chk(strm_enable && !strm_flag_clr, "R8", {strm_enable, strm_flag_clr}, 2'b10);
        chk(ctl_csn && !ctl_sclk, "R10", {ctl_csn, ctl_sclk}, 2'b10);
        chk(rdata == exp_rd, "R9", rdata, exp_rd);
        req_valid = 1'b0;
    endtask

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; ctl_miso = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ctl_csn && !ctl_sclk && !ctl_mosi, "R1", {ctl_csn, ctl_sclk, ctl_mosi}, 3'b100);
        chk(!busy && !done && !strm_flag_clr && strm_enable, "R1",
            {busy, done, strm_flag_clr, strm_enable}, 4'b0001);
        chk(rdata == 16'h0000, "R1", rdata, 0);
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(ctl_csn && !ctl_sclk && !busy, "R10", {ctl_csn, ctl_sclk, busy}, 3'b100);
        end
        for (int a = 0; a < 256; a++) begin
            run_txn(1'b1, a[7:0], wpat(a), 16'h0000, (a % 37) == 5);
        end
        for (int a = 0; a < 256; a += 2) begin
            run_txn(1'b0, a[7:0], 16'h0000, rpat(a), (a % 41) == 3);
        end
        run_txn(1'b0, 8'h5A, 16'h0000, 16'h8001, 1'b0);
        run_txn(1'b1, 8'h11, 16'hFFFF, 16'h0000, 1'b0);
        repeat (5) begin
            @(negedge clk);
            ctl_miso = ~ctl_miso;
            chk(rdata == 16'h8001, "R9", rdata, 16'h8001);
        end
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog (R6 completion) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule